// File: doc/BRIEF.md
# SD Command Issue Sequencer

This block sends a single command to an SD card model each time software writes its command register with the start bit set. It takes the command index and the argument from two 32-bit registers and presents them on a simple request/response interface toward the card. The reply comes back as 0, 4 or 16 bytes, or as an error flag. Valid replies are loaded into four 32-bit response words. Each outcome produces a one-cycle status-set pulse for a neighbouring interrupt block.

A command can also ask for the bus clock to be changed without any card traffic. In that case the block only reports completion. A command can also request an automatic stop: when the data-path logic reports that the remaining transfer count has reached zero, the sequencer sends the stop command (index 12, argument 0) by itself. The stored command and argument stay untouched, so software sees its own values afterwards. Software writes the registers through a word-addressed write port: word 0 is the command, word 1 is the argument, and words 2 to 5 are response words 0 to 3. The stored values are driven on readback outputs.

Top module: `sdcmd_seq`

## Requirements
- R1: When a command-register write with bit 31 set is accepted, the stored command shows bit 31 as 0. From the next cycle `busy` and `reqValid` are high until the reply or error is taken.
- R2: A started command with bit 21 set sends nothing to the card (`reqValid` stays low). It pulses `statusSet` bit 2 in the cycle after the write.
- R3: During a normal command, `reqIndex` carries command bits 5:0 and `reqArg` carries the argument register.
- R4: With bit 6 set and bit 7 clear, a 4-byte reply loads response word 0 with the first four received bytes. The first byte received lands in bits 31:24 (`rspData[127:120]` is the first byte). Words 1 to 3 are cleared, and `statusSet` bit 2 pulses.
- R5: With bits 6 and 7 set, a 16-byte reply loads word 0 with the last four bytes received and word 3 with the first four. Each word is big-endian, so word k equals `rspData[32k+31:32k]`.
- R6: An error flag, or a reply length that does not fit the short/long request, pulses `statusSet` bit 1 instead of bit 2 and leaves the response words unchanged.
- R7: With bit 6 clear, any non-error reply completes with `statusSet` bit 2 and leaves the response words unchanged.
- R8: When command bit 12 is set and `dataDone` pulses, the block sends index 12 with argument 0. The stored command and argument are unchanged. On the reply it pulses `statusSet` bit 14 together with bit 2 or bit 1.
- R9: While `busy` is high, writes to the command and argument registers are ignored, and so is a new start.
- R10: Software writes to response words are accepted. The response words hold their value until such a write or the next loaded reply.
- R11: A `dataDone` pulse while command bit 12 is clear issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Word address: 0 command, 1 argument, 2-5 response words 0-3 |
| regWrData | input | 32 | Register write data |
| dataDone | input | 1 | Pulse: remaining transfer count reached zero |
| reqValid | output | 1 | Request to card pending |
| reqIndex | output | 6 | Command index presented to card |
| reqArg | output | 32 | Argument presented to card |
| rspValid | input | 1 | Reply or error from card this cycle |
| rspError | input | 1 | Card/bus error with the reply |
| rspLen | input | 5 | Reply length in bytes (0, 4 or 16) |
| rspData | input | 128 | Reply bytes, first received in bits 127:120 |
| busy | output | 1 | Command in flight or stop command pending |
| cmdWord | output | 32 | Stored command register |
| argWord | output | 32 | Stored argument register |
| respWords | output | 128 | Response words, word k in bits 32k+31:32k |
| statusSet | output | 16 | One-cycle status pulses: bit 1 no response, bit 2 done, bit 14 auto stop done |

## Verification
The main function is driven with short and long replies whose bytes are all distinct, so a swapped word or a byte-order error shows up in the loaded words. The same requests are then answered with mismatched lengths, with the error flag, and with no reply expected. These separate the no-response path from the completion path, and also show whether the response words were disturbed. A clock-change-only command and a command started while another is in flight test the bus bypass and the busy lockout. An auto-stop run compares the index and argument on the card side against the stored registers, to confirm the save and restore.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int WORD_W    = 32;
  localparam int RSP_WORDS = 4;
  localparam int RSP_BITS  = WORD_W * RSP_WORDS;
  localparam int IDX_W     = 6;
  localparam int LEN_W     = 5;

  // command register bit positions
  localparam int START_BIT    = 31;
  localparam int CLKCHG_BIT   = 21;
  localparam int AUTOSTOP_BIT = 12;
  localparam int LONG_BIT     = 7;
  localparam int RSPEXP_BIT   = 6;

  // status-set bit positions decoded by the interrupt block
  localparam int ST_NORSP = 1;
  localparam int ST_DONE  = 2;
  localparam int ST_AUTO  = 14;

  localparam logic [IDX_W-1:0] STOP_INDEX = 6'd12;
  localparam logic [LEN_W-1:0] SHORT_LEN  = 5'd4;
  localparam logic [LEN_W-1:0] LONG_LEN   = 5'd16;

  // register word addresses
  localparam int ADDR_CMD  = 0;
  localparam int ADDR_ARG  = 1;
  localparam int ADDR_RSP0 = 2;

  typedef enum logic [1:0] {S_IDLE, S_WAIT_CMD, S_WAIT_STOP} seqState_t;

  typedef struct packed {
    logic cmdWr;
    logic argWr;
    logic rspLoad;
    logic stopSel;
  } dpStrobe_t;
endpackage

// File: rtl/sdcmd_dpath.sv
module sdcmd_dpath
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [WORD_W-1:0]   regWrData,
  input  logic                rspError,
  input  logic [LEN_W-1:0]    rspLen,
  input  logic [RSP_BITS-1:0] rspData,
  output logic [WORD_W-1:0]   cmdWord,
  output logic [WORD_W-1:0]   argWord,
  output logic [RSP_BITS-1:0] respWords,
  output logic [IDX_W-1:0]    reqIndex,
  output logic [WORD_W-1:0]   reqArg,
  output logic                rspGood
);
  logic longReq, rspExp;
  assign longReq = cmdWord[LONG_BIT];
  assign rspExp  = cmdWord[RSPEXP_BIT];

  always_comb begin
    if (rspError)     rspGood = 1'b0;
    else if (!rspExp) rspGood = 1'b1;
    else              rspGood = longReq ? (rspLen == LONG_LEN) : (rspLen == SHORT_LEN);
  end

  // stop command substitutes index and argument on the wire only
  assign reqIndex = strobe.stopSel ? STOP_INDEX : cmdWord[IDX_W-1:0];
  assign reqArg   = strobe.stopSel ? '0 : argWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdWord <= '0;
      argWord <= '0;
    end else begin
      if (strobe.cmdWr) cmdWord <= {1'b0, regWrData[WORD_W-2:0]};
      if (strobe.argWr) argWord <= regWrData;
    end
  end

  for (genvar i = 0; i < RSP_WORDS; i++) begin : g_rsp
    logic [WORD_W-1:0] nextWord;
    logic              swHit;
    assign swHit = regWrEn && (int'(regAddr) == ADDR_RSP0 + i);
    if (i == 0) begin : g_first
      assign nextWord = longReq ? rspData[WORD_W-1:0] : rspData[RSP_BITS-1 -: WORD_W];
    end else begin : g_rest
      assign nextWord = longReq ? rspData[WORD_W*i +: WORD_W] : '0;
    end
    always_ff @(posedge clk) begin
      if (!rstN)               respWords[WORD_W*i +: WORD_W] <= '0;
      else if (strobe.rspLoad) respWords[WORD_W*i +: WORD_W] <= nextWord;
      else if (swHit)          respWords[WORD_W*i +: WORD_W] <= regWrData;
    end
  end
endmodule

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int STATUS_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [WORD_W-1:0]   regWrData,
  input  logic                dataDone,
  input  logic                cmdAutoStop,
  input  logic                cmdRspExp,
  input  logic                rspValid,
  input  logic                rspGood,
  output dpStrobe_t           strobe,
  output logic                reqValid,
  output logic                busy,
  output logic [STATUS_W-1:0] statusSet
);
  seqState_t state;
  logic      autoPend;
  logic      startNow, clkOnly, rspTake, stopReq;

  assign busy     = (state != S_IDLE) || autoPend;
  assign reqValid = (state != S_IDLE);
  assign rspTake  = reqValid && rspValid;
  assign stopReq  = dataDone && cmdAutoStop;

  assign strobe.cmdWr   = regWrEn && (int'(regAddr) == ADDR_CMD) && !busy;
  assign strobe.argWr   = regWrEn && (int'(regAddr) == ADDR_ARG) && !busy;
  assign strobe.rspLoad = rspTake && rspGood && cmdRspExp;
  assign strobe.stopSel = (state == S_WAIT_STOP);

  assign startNow = strobe.cmdWr && regWrData[START_BIT];
  assign clkOnly  = startNow && regWrData[CLKCHG_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      autoPend  <= 1'b0;
      statusSet <= '0;
    end else begin
      statusSet <= '0;
      unique case (state)
        S_IDLE: begin
          if (autoPend) begin
            state    <= S_WAIT_STOP;
            autoPend <= 1'b0;
          end else if (clkOnly) begin
            statusSet[ST_DONE] <= 1'b1;
          end else if (startNow) begin
            state <= S_WAIT_CMD;
          end
        end
        S_WAIT_CMD, S_WAIT_STOP: begin
          if (rspValid) begin
            if (rspGood) statusSet[ST_DONE]  <= 1'b1;
            else         statusSet[ST_NORSP] <= 1'b1;
            if (state == S_WAIT_STOP) statusSet[ST_AUTO] <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (stopReq) autoPend <= 1'b1;
    end
  end
endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int STATUS_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [WORD_W-1:0]   regWrData,
  input  logic                dataDone,
  output logic                reqValid,
  output logic [IDX_W-1:0]    reqIndex,
  output logic [WORD_W-1:0]   reqArg,
  input  logic                rspValid,
  input  logic                rspError,
  input  logic [LEN_W-1:0]    rspLen,
  input  logic [RSP_BITS-1:0] rspData,
  output logic                busy,
  output logic [WORD_W-1:0]   cmdWord,
  output logic [WORD_W-1:0]   argWord,
  output logic [RSP_BITS-1:0] respWords,
  output logic [STATUS_W-1:0] statusSet
);
  dpStrobe_t strobe;
  logic      rspGood;

  sdcmd_ctrl #(.ADDR_W(ADDR_W), .STATUS_W(STATUS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .dataDone(dataDone),
    .cmdAutoStop(cmdWord[AUTOSTOP_BIT]), .cmdRspExp(cmdWord[RSPEXP_BIT]),
    .rspValid(rspValid), .rspGood(rspGood), .strobe(strobe),
    .reqValid(reqValid), .busy(busy), .statusSet(statusSet)
  );

  sdcmd_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .rspError(rspError),
    .rspLen(rspLen), .rspData(rspData), .cmdWord(cmdWord),
    .argWord(argWord), .respWords(respWords), .reqIndex(reqIndex),
    .reqArg(reqArg), .rspGood(rspGood)
  );
endmodule

// File: rtl/sdcmd_chk.sv
module sdcmd_chk
  import sdcmd_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int STATUS_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [WORD_W-1:0]   regWrData,
  input logic                dataDone,
  input logic                reqValid,
  input logic [IDX_W-1:0]    reqIndex,
  input logic [WORD_W-1:0]   reqArg,
  input logic                rspValid,
  input logic                rspError,
  input logic [LEN_W-1:0]    rspLen,
  input logic [RSP_BITS-1:0] rspData,
  input logic                busy,
  input logic [WORD_W-1:0]   cmdWord,
  input logic [WORD_W-1:0]   argWord,
  input logic [RSP_BITS-1:0] respWords,
  input logic [STATUS_W-1:0] statusSet
);
  logic cmdStart, rspSwWr;
  assign cmdStart = regWrEn && (int'(regAddr) == ADDR_CMD) && !busy && regWrData[START_BIT];
  assign rspSwWr  = regWrEn && (int'(regAddr) >= ADDR_RSP0) && (int'(regAddr) < ADDR_RSP0 + RSP_WORDS);

  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !cmdWord[START_BIT]);

  a_r2_clkchg_no_bus: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart && regWrData[CLKCHG_BIT] |=> statusSet[ST_DONE] && !reqValid);

  a_r6_status_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(statusSet[ST_DONE] && statusSet[ST_NORSP]));

  a_r8_auto_with_outcome: assert property (@(posedge clk) disable iff (!rstN)
    statusSet[ST_AUTO] |-> (statusSet[ST_DONE] || statusSet[ST_NORSP]));

  a_r9_req_implies_busy: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> busy);

  a_r9_regs_frozen: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> $stable(cmdWord) && $stable(argWord));

  a_r10_resp_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rspSwWr && !(reqValid && rspValid) |=> $stable(respWords));

  a_r4_short_clears_upper: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && rspValid && !rspError && cmdWord[RSPEXP_BIT] && !cmdWord[LONG_BIT]
      && rspLen == SHORT_LEN |=> respWords[RSP_BITS-1:WORD_W] == '0);
endmodule

bind sdcmd_seq sdcmd_chk #(.ADDR_W(ADDR_W), .STATUS_W(STATUS_W)) u_chk (.*);

// File: tb/sim_sdcmd_seq.sv
`timescale 1ns/1ps
module sim_sdcmd_seq;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrEn = 1'b0;
  logic [2:0]   regAddr = '0;
  logic [31:0]  regWrData = '0;
  logic         dataDone = 1'b0;
  logic         reqValid;
  logic [5:0]   reqIndex;
  logic [31:0]  reqArg;
  logic         rspValid = 1'b0;
  logic         rspError = 1'b0;
  logic [4:0]   rspLen = '0;
  logic [127:0] rspData = '0;
  logic         busy;
  logic [31:0]  cmdWord, argWord;
  logic [127:0] respWords;
  logic [15:0]  statusSet;

  int nChk = 0;
  int nFail = 0;

  localparam logic [31:0] START = 32'h8000_0000;
  localparam logic [31:0] CLKCH = 32'h0020_0000;
  localparam logic [31:0] ASTOP = 32'h0000_1000;
  localparam logic [31:0] LONGR = 32'h0000_0080;
  localparam logic [31:0] REXP  = 32'h0000_0040;
  localparam logic [15:0] S_DONE = 16'h0004;
  localparam logic [15:0] S_NORSP = 16'h0002;
  localparam logic [15:0] S_AUTO = 16'h4000;
  localparam logic [127:0] PAT_A = 128'h00112233_44556677_8899AABB_CCDDEEFF;
  localparam logic [127:0] PAT_B = 128'hA1A2A3A4_B1B2B3B4_C1C2C3C4_D1D2D3D4;

  always #4 clk = ~clk;

  sdcmd_seq u0 (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic respond(input logic err, input logic [4:0] len, input logic [127:0] d);
    for (int i = 0; i < 10 && !reqValid; i++) @(negedge clk);
    rspValid = 1'b1; rspError = err; rspLen = len; rspData = d;
    @(negedge clk);
    rspValid = 1'b0; rspError = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset busy", busy, 0);
    chk("R1 reset reqValid", reqValid, 0);
    chk("R10 reset resp", respWords, 0);
    chk("R6 reset status", statusSet, 0);
  endtask

  task automatic t_short();
    wr(1, 32'hCAFE_0001);
    wr(0, START | REXP | 32'd17);
    chk("R1 start bit cleared", cmdWord[31], 0);
    chk("R1 busy", busy, 1);
    chk("R3 index", reqIndex, 17);
    chk("R3 arg", reqArg, 32'hCAFE_0001);
    respond(0, 4, PAT_A);
    chk("R4 status done", statusSet, S_DONE);
    chk("R4 short load", respWords, {96'h0, PAT_A[127:96]});
    chk("R1 idle after reply", busy, 0);
  endtask

  task automatic t_long();
    wr(5, 32'h5555_0003);
    chk("R10 sw write word3", respWords[127:96], 32'h5555_0003);
    wr(0, START | REXP | LONGR | 32'd2);
    respond(0, 16, PAT_B);
    chk("R5 status done", statusSet, S_DONE);
    chk("R5 word0 last bytes", respWords[31:0], PAT_B[31:0]);
    chk("R5 word3 first bytes", respWords[127:96], PAT_B[127:96]);
    chk("R5 all words", respWords, PAT_B);
  endtask

  task automatic t_errors();
    wr(0, START | REXP | 32'd9);
    respond(0, 16, PAT_A);
    chk("R6 length mismatch", statusSet, S_NORSP);
    chk("R6 resp unchanged", respWords, PAT_B);
    wr(0, START | REXP | LONGR | 32'd9);
    respond(0, 4, PAT_A);
    chk("R6 long got short", statusSet, S_NORSP);
    wr(0, START | REXP | 32'd9);
    respond(1, 4, PAT_A);
    chk("R6 bus error", statusSet, S_NORSP);
    chk("R6 resp unchanged after error", respWords, PAT_B);
  endtask

  task automatic t_noresp();
    wr(0, START | 32'd0);
    respond(0, 0, PAT_A);
    chk("R7 done without reply", statusSet, S_DONE);
    chk("R7 resp untouched", respWords, PAT_B);
  endtask

  task automatic t_clkchg();
    wr(0, START | CLKCH | REXP | 32'd3);
    chk("R2 done pulse", statusSet, S_DONE);
    chk("R2 no request", reqValid, 0);
    @(negedge clk);
    chk("R2 still idle", busy, 0);
    chk("R2 pulse one cycle", statusSet, 0);
  endtask

  task automatic t_busy();
    wr(1, 32'h0000_AAAA);
    wr(0, START | REXP | 32'd5);
    wr(0, START | REXP | 32'd9);
    wr(1, 32'h0000_BBBB);
    chk("R9 index kept", reqIndex, 5);
    chk("R9 cmd kept", cmdWord, REXP | 32'd5);
    chk("R9 arg kept", argWord, 32'h0000_AAAA);
    respond(0, 4, PAT_B);
    chk("R9 completes", statusSet, S_DONE);
    @(negedge clk);
    chk("R9 no second command", reqValid, 0);
  endtask

  task automatic t_autostop();
    wr(1, 32'h0000_1234);
    wr(0, START | ASTOP | REXP | 32'd18);
    respond(0, 4, PAT_A);
    @(negedge clk);
    dataDone = 1'b1;
    @(negedge clk);
    dataDone = 1'b0;
    chk("R8 busy pending", busy, 1);
    for (int i = 0; i < 10 && !reqValid; i++) @(negedge clk);
    chk("R8 stop index", reqIndex, 12);
    chk("R8 stop arg", reqArg, 0);
    respond(0, 4, PAT_B);
    chk("R8 status", statusSet, S_DONE | S_AUTO);
    chk("R8 cmd restored", cmdWord, ASTOP | REXP | 32'd18);
    chk("R8 arg restored", argWord, 32'h0000_1234);
    chk("R8 resp loaded", respWords, {96'h0, PAT_B[127:96]});
  endtask

  task automatic t_nostop();
    wr(0, START | REXP | 32'd7);
    respond(0, 4, PAT_A);
    @(negedge clk);
    dataDone = 1'b1;
    @(negedge clk);
    dataDone = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 no stop issued", reqValid, 0);
    chk("R11 not busy", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_short();
    t_long();
    t_errors();
    t_noresp();
    t_clkchg();
    t_busy();
    t_autostop();
    t_nostop();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule